// File: doc/BRIEF.md
# Four-Channel Chainable Tone Divider

This block holds four 8-bit down-counting period dividers that set the pitch of four sound channels. Each divider advances only on cycles where its chosen clock-enable strobe is high. When it reaches zero it reloads from its period register and sends a one-cycle pulse on its channel output. Later stages use that pulse to toggle a square wave or to sample noise. The block has no derived clocks. Everything runs on the master clock, and three single-cycle strobes give the fast rate, the 64 kHz rate and the 15 kHz rate.

A shared control byte sets how the dividers run. One bit picks the common slow base rate. Two bits move divider 1 and divider 3 onto the fast strobe. Two more bits join divider 2 to divider 1, and divider 4 to divider 3. A joined pair is one 16-bit divider: the higher-numbered channel's register holds the upper byte of the period. With these bits the four counters can serve as four 8-bit channels, as two 16-bit channels, or as one 16-bit channel and two 8-bit channels.

Top module: `tone_div4`

## Requirements
- R1: Synchronous active-high reset clears all four counters to zero and holds every pulse output low. Because the counters start at zero, the first enable a channel sees after reset makes it pulse.
- R2: An unjoined channel with period value N pulses once every N+1 of its enables. Each pulse is exactly one clock wide and shows on `tone_pulse` in the cycle after the enable that found the counter at zero.
- R3: Control bit 0 chooses the base strobe. Clear selects `tick_64k` and set selects `tick_15k`. Channels 2 and 4 always use the base strobe, and channels 1 and 3 use it unless moved to the fast strobe.
- R4: Control bit 6 set makes channel 1 count on `tick_fast`. Control bit 5 set does the same for channel 3.
- R5: Control bit 4 set joins channels 1 and 2 into one 16-bit counter. It counts on channel 1's enable with period {freq2, freq1}+1, and channel 2 (`tone_pulse[1]`) pulses when that counter reloads.
- R6: Control bit 3 set joins channels 3 and 4 in the same way. The period is {freq4, freq3}+1, counted on channel 3's enable, and channel 4 (`tone_pulse[3]`) gives the 16-bit pulse.
- R7: In a joined pair the low channel keeps counting. Its pulse marks every enable where the low byte is zero. The high channel's own base strobe has no effect on either output while the pair is joined.
- R8: A change to a period register does not change the count already in progress. The new value is used from the next reload.
- R9: The full range of period values works at both ends. A value of 0 with an enable on every cycle gives a pulse on every cycle. A value of 255 gives one pulse per 256 enables.
- R10: The two pairs are configured independently. The same control byte can set one 16-bit pair and two separate 8-bit channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fast | input | 1 | Fast-rate enable strobe |
| tick_64k | input | 1 | 64 kHz enable strobe |
| tick_15k | input | 1 | 15 kHz enable strobe |
| freq1 | input | 8 | Period value, channel 1 |
| freq2 | input | 8 | Period value, channel 2 (upper byte when joined) |
| freq3 | input | 8 | Period value, channel 3 |
| freq4 | input | 8 | Period value, channel 4 (upper byte when joined) |
| ctrl | input | 8 | Shared control byte: bit 0 base select, bit 3 join 3/4, bit 4 join 1/2, bit 5 fast ch3, bit 6 fast ch1 |
| tone_pulse | output | 4 | Terminal-count pulses, bit k for channel k+1 |

## Verification
The bench first drives periodic base strobes with four different short periods. This separates a divide-by-N error from a divide-by-N+1 error. It then drives 64 kHz and 15 kHz strobes at different rates, so each setting of the base-select bit leaves its own pulse spacing. Runs with fast strobes, with each pair joined alone and with both pairs joined, expose wrong routing between channels and a wrong byte order in the 16-bit period. A period change part-way through a count, plus random strobe patterns, checks when a new value takes effect. Together these cover reload timing and the two period extremes.

// File: rtl/tone_div_pkg.sv
package tone_div_pkg;
    localparam int CNT_W     = 8;
    localparam int NUM_PAIRS = 2;
    localparam int NUM_CH    = 2 * NUM_PAIRS;

    localparam int CB_BASE15 = 0;
    localparam int CB_JOIN34 = 3;
    localparam int CB_JOIN12 = 4;
    localparam int CB_FAST3  = 5;
    localparam int CB_FAST1  = 6;

    typedef struct packed {
        logic join_en;
        logic en_lo;
        logic en_hi;
    } pair_cfg_t;

    function automatic logic is_zero8(input logic [CNT_W-1:0] v);
        return v == '0;
    endfunction
endpackage

// File: rtl/tone_div_route.sv
module tone_div_route
    import tone_div_pkg::*;
(
    input  logic                      tick_fast,
    input  logic                      tick_64k,
    input  logic                      tick_15k,
    input  logic [7:0]                ctrl,
    output pair_cfg_t [NUM_PAIRS-1:0] cfg
);
    logic base_tick;
    assign base_tick = ctrl[CB_BASE15] ? tick_15k : tick_64k;

    localparam int FAST_BIT [NUM_PAIRS] = '{CB_FAST1, CB_FAST3};
    localparam int JOIN_BIT [NUM_PAIRS] = '{CB_JOIN12, CB_JOIN34};

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        always_comb begin
            cfg[p].join_en = ctrl[JOIN_BIT[p]];
            cfg[p].en_lo   = ctrl[FAST_BIT[p]] ? tick_fast : base_tick;
            cfg[p].en_hi   = base_tick;
        end
    end
endmodule

// File: rtl/tone_div_pair.sv
module tone_div_pair
    import tone_div_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  pair_cfg_t    cfg,
    input  logic [W-1:0] per_lo,
    input  logic [W-1:0] per_hi,
    output logic         tc_lo,
    output logic         tc_hi
);
    localparam int WW = 2 * W;

    logic [W-1:0]  cnt_lo, cnt_hi, nxt_lo, nxt_hi;
    logic [WW-1:0] joined, joined_dec;
    logic          p_lo, p_hi;

    assign joined     = {cnt_hi, cnt_lo};
    assign joined_dec = joined - WW'(1);

    always_comb begin
        nxt_lo = cnt_lo;
        nxt_hi = cnt_hi;
        p_lo   = 1'b0;
        p_hi   = 1'b0;
        if (cfg.join_en) begin
            if (cfg.en_lo) begin
                p_lo = (cnt_lo == '0);
                if (joined == '0) begin
                    nxt_lo = per_lo;
                    nxt_hi = per_hi;
                    p_hi   = 1'b1;
                end else begin
                    {nxt_hi, nxt_lo} = joined_dec;
                end
            end
        end else begin
            if (cfg.en_lo) begin
                if (cnt_lo == '0) begin
                    nxt_lo = per_lo;
                    p_lo   = 1'b1;
                end else begin
                    nxt_lo = cnt_lo - W'(1);
                end
            end
            if (cfg.en_hi) begin
                if (cnt_hi == '0) begin
                    nxt_hi = per_hi;
                    p_hi   = 1'b1;
                end else begin
                    nxt_hi = cnt_hi - W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
            tc_lo  <= 1'b0;
            tc_hi  <= 1'b0;
        end else begin
            cnt_lo <= nxt_lo;
            cnt_hi <= nxt_hi;
            tc_lo  <= p_lo;
            tc_hi  <= p_hi;
        end
    end

    // R2: a low-channel pulse always follows an enable on that channel
    a_r2_lo_needs_enable: assert property (@(posedge clk) disable iff (rst)
        tc_lo |-> $past(cfg.en_lo));

    // R7: the high pulse follows the enable that belongs to the current mode
    a_r7_hi_source: assert property (@(posedge clk) disable iff (rst)
        tc_hi |-> ($past(cfg.join_en) ? $past(cfg.en_lo) : $past(cfg.en_hi)));

    // R5 / R6: a joined 16-bit reload coincides with a low-byte pulse
    a_r5_hi_with_lo: assert property (@(posedge clk) disable iff (rst)
        (tc_hi && $past(cfg.join_en)) |-> tc_lo);

    // R8: an unjoined reload takes the register value seen at that edge
    a_r8_reload_value: assert property (@(posedge clk) disable iff (rst)
        (tc_lo && !$past(cfg.join_en)) |-> (cnt_lo == $past(per_lo)));

    // R6: a joined reload loads both bytes of the 16-bit period
    a_r6_joined_reload: assert property (@(posedge clk) disable iff (rst)
        (tc_hi && $past(cfg.join_en)) |-> (joined == {$past(per_hi), $past(per_lo)}));
endmodule

// File: rtl/tone_div4.sv
module tone_div4
    import tone_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_fast,
    input  logic       tick_64k,
    input  logic       tick_15k,
    input  logic [7:0] freq1,
    input  logic [7:0] freq2,
    input  logic [7:0] freq3,
    input  logic [7:0] freq4,
    input  logic [7:0] ctrl,
    output logic [3:0] tone_pulse
);
    pair_cfg_t [NUM_PAIRS-1:0] cfg;
    logic [CNT_W-1:0]          per [NUM_CH];

    assign per[0] = freq1;
    assign per[1] = freq2;
    assign per[2] = freq3;
    assign per[3] = freq4;

    tone_div_route u_route (
        .tick_fast (tick_fast),
        .tick_64k  (tick_64k),
        .tick_15k  (tick_15k),
        .ctrl      (ctrl),
        .cfg       (cfg)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        tone_div_pair #(.W(CNT_W)) u_pair (
            .clk    (clk),
            .rst    (rst),
            .cfg    (cfg[p]),
            .per_lo (per[2*p]),
            .per_hi (per[2*p+1]),
            .tc_lo  (tone_pulse[2*p]),
            .tc_hi  (tone_pulse[2*p+1])
        );
    end
endmodule

// File: tb/tone_div4_tb.sv
module tone_div4_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_fast = 1'b0, tick_64k = 1'b0, tick_15k = 1'b0;
    logic [7:0] freq1 = 8'd0, freq2 = 8'd0, freq3 = 8'd0, freq4 = 8'd0;
    logic [7:0] ctrl = 8'd0;
    logic [3:0] tone_pulse;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    int m_lo [2];
    int m_hi [2];

    always #10 clk = ~clk;

    tone_div4 u_dut (
        .clk(clk), .rst(rst), .tick_fast(tick_fast), .tick_64k(tick_64k),
        .tick_15k(tick_15k), .freq1(freq1), .freq2(freq2), .freq3(freq3),
        .freq4(freq4), .ctrl(ctrl), .tone_pulse(tone_pulse)
    );

    // monitor: compares each expected item shortly after the edge it refers to
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            total++;
            if (tone_pulse !== it.exp) begin
                bad++;
                $display("FAIL %s: tone_pulse=%b expected=%b at %0t", it.tag, tone_pulse, it.exp, $time);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick_fast = 0; tick_64k = 0; tick_15k = 0;
        for (int p = 0; p < 2; p++) begin m_lo[p] = 0; m_hi[p] = 0; end
        @(negedge clk);
        @(negedge clk);
        total++;
        if (tone_pulse !== 4'b0000) begin
            bad++;
            $display("FAIL R1: reset tone_pulse=%b expected=0000", tone_pulse);
        end
        rst = 1'b0;
    endtask

    // driver: applies one cycle of strobes and pushes the expected result
    task automatic drive(input logic tf, input logic t64, input logic t15, input string tag);
        logic base;
        logic en_lo [2];
        logic en_hi [2];
        logic jn [2];
        int   plo [2];
        int   phi [2];
        logic [3:0] e;
        @(negedge clk);
        tick_fast = tf; tick_64k = t64; tick_15k = t15;
        base = ctrl[0] ? t15 : t64;
        en_lo[0] = ctrl[6] ? tf : base;
        en_lo[1] = ctrl[5] ? tf : base;
        en_hi[0] = base; en_hi[1] = base;
        jn[0] = ctrl[4]; jn[1] = ctrl[3];
        plo[0] = freq1; phi[0] = freq2; plo[1] = freq3; phi[1] = freq4;
        e = 4'b0000;
        for (int p = 0; p < 2; p++) begin
            if (jn[p]) begin
                if (en_lo[p]) begin
                    int v;
                    v = m_hi[p] * 256 + m_lo[p];
                    e[2*p] = (m_lo[p] == 0);
                    if (v == 0) begin
                        e[2*p+1] = 1'b1;
                        m_lo[p] = plo[p]; m_hi[p] = phi[p];
                    end else begin
                        v = v - 1;
                        m_lo[p] = v % 256; m_hi[p] = v / 256;
                    end
                end
            end else begin
                if (en_lo[p]) begin
                    if (m_lo[p] == 0) begin e[2*p] = 1'b1; m_lo[p] = plo[p]; end
                    else m_lo[p] = m_lo[p] - 1;
                end
                if (en_hi[p]) begin
                    if (m_hi[p] == 0) begin e[2*p+1] = 1'b1; m_hi[p] = phi[p]; end
                    else m_hi[p] = m_hi[p] - 1;
                end
            end
        end
        sb_q.push_back('{exp: e, tag: tag});
    endtask

    task automatic run_pattern(input int n, input int pf, input int p64, input int p15, input string tag);
        for (int i = 0; i < n; i++)
            drive(pf != 0 && (i % pf) == 0, p64 != 0 && (i % p64) == 0, p15 != 0 && (i % p15) == 0, tag);
    endtask

    task automatic run_random(input int n, input string tag);
        for (int i = 0; i < n; i++)
            drive(1'($urandom), 1'($urandom), 1'($urandom), tag);
    endtask

    task automatic finish_run();
        @(negedge clk);
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 100000) begin
                bad++;
                total++;
                $display("FAIL watchdog: cycles=%0d expected<=100000", wd);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state and first-enable pulse on every channel
        do_reset();
        ctrl = 8'h00; freq1 = 8'd2; freq2 = 8'd0; freq3 = 8'd5; freq4 = 8'd1;
        drive(1'b0, 1'b1, 1'b0, "R1");
        // R2: four 8-bit channels on the 64k base strobe
        run_pattern(120, 0, 3, 0, "R2");
        // R3: base select 15k while 64k toggles at another rate
        do_reset();
        ctrl = 8'h01; freq1 = 8'd1; freq2 = 8'd3; freq3 = 8'd0; freq4 = 8'd2;
        run_pattern(150, 0, 2, 5, "R3");
        ctrl = 8'h00;
        run_pattern(100, 0, 2, 5, "R3");
        // R4: channels 1 and 3 on the fast strobe
        do_reset();
        ctrl = 8'h60; freq1 = 8'd3; freq2 = 8'd1; freq3 = 8'd6; freq4 = 8'd4;
        run_pattern(150, 1, 4, 7, "R4");
        // R5 / R7: channels 1 and 2 joined, fast, period 0x0103+1
        do_reset();
        ctrl = 8'h50; freq1 = 8'h03; freq2 = 8'h01; freq3 = 8'd2; freq4 = 8'd3;
        run_pattern(600, 1, 3, 5, "R5");
        // R6 / R10: both pairs joined, then only 3/4 joined
        do_reset();
        ctrl = 8'h18; freq1 = 8'd4; freq2 = 8'd0; freq3 = 8'h00; freq4 = 8'h01;
        run_pattern(560, 2, 2, 3, "R6");
        ctrl = 8'h08;
        run_pattern(300, 2, 2, 3, "R10");
        // R7: joined pair ignores the high channel's own base strobe
        do_reset();
        ctrl = 8'h10; freq1 = 8'd2; freq2 = 8'd0; freq3 = 8'd1; freq4 = 8'd1;
        run_pattern(200, 0, 1, 0, "R7");
        // R8: period change mid-count takes effect at next reload
        do_reset();
        ctrl = 8'h40; freq1 = 8'd10; freq2 = 8'd2; freq3 = 8'd3; freq4 = 8'd1;
        run_pattern(5, 1, 0, 0, "R8");
        freq1 = 8'd2;
        run_pattern(40, 1, 0, 0, "R8");
        // R9: extremes, 0 with every-cycle enable and 255
        do_reset();
        ctrl = 8'h60; freq1 = 8'd0; freq2 = 8'd255; freq3 = 8'd255; freq4 = 8'd0;
        run_pattern(600, 1, 1, 0, "R9");
        // R10: random strobes with mixed configuration
        do_reset();
        ctrl = 8'h11; freq1 = 8'd1; freq2 = 8'd0; freq3 = 8'd4; freq4 = 8'd2;
        run_random(800, "R10");
        finish_run();
    end
endmodule